// File: doc/BRIEF.md
# Base-Offset Address Generator with Base Writeback

This block forms the memory address for a load or store. Only loads and stores reach memory, and each of them names a base register and an unsigned immediate offset. A direction bit chooses whether the offset is added to the base or subtracted from it. A two-bit variant code then decides two things. The first is whether the access uses the combined value or the untouched base. The second is whether the combined value goes back into the base register.

In the plain offset variant the base register keeps its value. In the pre-indexed variant the access and the writeback both use the combined value. In the post-indexed variant the access uses the old base and the combined value is written back. One input strobe produces one result on the following clock edge. The result carries a valid flag, a base write-enable and a flag for an illegal variant code.

Top module: `bo_agu`

## Requirements
- R1: While reset is asserted and until the first strobe, outValid, baseWe and badVariant are 0, and memAddr and baseNew are all zeros.
- R2: outValid is 1 in the cycle after a cycle with inValid high, and 0 in the cycle after a cycle with inValid low.
- R3: Variant code 2'b00 (offset): memAddr is base combined with offset, and baseWe is 0.
- R4: Variant code 2'b01 (pre-index): memAddr and baseNew both equal base combined with offset, and baseWe is 1.
- R5: Variant code 2'b10 (post-index): memAddr equals the unmodified base, baseNew equals base combined with offset, and baseWe is 1.
- R6: The offset is zero-extended to ADDR_W bits. addUp=1 adds it to the base and addUp=0 subtracts it from the base, wrapping modulo 2^ADDR_W.
- R7: Variant code 2'b11 is reserved. It raises badVariant, keeps baseWe at 0, and drives memAddr with the unmodified base.
- R8: For every accepted strobe, baseNew equals base combined with offset, whatever the variant code.
- R9: After a cycle without a strobe, baseWe and badVariant are 0, and memAddr and baseNew keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Strobe: a load/store address request is present |
| baseIn | input | ADDR_W | Current base register value |
| offsetIn | input | OFF_W | Unsigned immediate offset |
| addUp | input | 1 | 1 adds the offset, 0 subtracts it |
| variant | input | 2 | 00 offset, 01 pre-index, 10 post-index, 11 reserved |
| outValid | output | 1 | Result valid, one cycle after the strobe |
| memAddr | output | ADDR_W | Address used for the memory access |
| baseNew | output | ADDR_W | Value to write back to the base register |
| baseWe | output | 1 | Base register write-enable |
| badVariant | output | 1 | Reserved variant code was received |

## Verification
The access address and the base writeback value appear in the same output cycle. In the post-indexed variant they must differ, and a single cycle shows whether each one took the correct operand. This case is provoked by sweeping every base, every offset and both directions of an 8-bit, 4-bit-offset configuration through all four variant codes. The sweep includes nonzero offsets that wrap past zero or past the top of the range. In each cycle both values, along with baseWe and badVariant, are compared against sums that the bench computes with its own modular arithmetic. The strobes arrive back to back with occasional idle cycles, so every result is also checked against the neighbouring request and against the hold behaviour.

// File: rtl/bo_agu_pkg.sv
package bo_agu_pkg;

  typedef enum logic [1:0] {
    VarOffset = 2'b00,
    VarPre    = 2'b01,
    VarPost   = 2'b10,
    VarRsvd   = 2'b11
  } variant_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;       // latch a new result this cycle
    logic addrFromBase;  // access uses the unmodified base
  } dpStrobe_t;

endpackage

// File: rtl/bo_agu_ctrl.sv
module bo_agu_ctrl
  import bo_agu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] variant,
  output dpStrobe_t  strobe,
  output logic       outValid,
  output logic       baseWe,
  output logic       badVariant
);

  logic wbEn;
  logic isBad;

  always_comb begin
    strobe.capture      = inValid;
    strobe.addrFromBase = 1'b0;
    wbEn                = 1'b0;
    isBad               = 1'b0;
    case (variant_e'(variant))
      VarOffset: ;
      VarPre:    wbEn = 1'b1;
      VarPost: begin
        wbEn                = 1'b1;
        strobe.addrFromBase = 1'b1;
      end
      default: begin
        isBad               = 1'b1;
        strobe.addrFromBase = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      baseWe     <= 1'b0;
      badVariant <= 1'b0;
    end else begin
      outValid   <= inValid;
      baseWe     <= inValid & wbEn;
      badVariant <= inValid & isBad;
    end
  end

endmodule

// File: rtl/bo_agu_dpath.sv
module bo_agu_dpath
  import bo_agu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [OFF_W-1:0]  offsetIn,
  input  logic              addUp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] baseNew
);

  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] combined;
  logic [ADDR_W-1:0] accessAddr;

  assign offExt     = ADDR_W'(offsetIn);
  assign combined   = addUp ? (baseIn + offExt) : (baseIn - offExt);
  assign accessAddr = strobe.addrFromBase ? baseIn : combined;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      baseNew <= '0;
    end else if (strobe.capture) begin
      memAddr <= accessAddr;
      baseNew <= combined;
    end
  end

endmodule

// File: rtl/bo_agu.sv
module bo_agu
  import bo_agu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [OFF_W-1:0]  offsetIn,
  input  logic              addUp,
  input  logic [1:0]        variant,
  output logic              outValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] baseNew,
  output logic              baseWe,
  output logic              badVariant
);

  dpStrobe_t strobe;

  bo_agu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .variant   (variant),
    .strobe    (strobe),
    .outValid  (outValid),
    .baseWe    (baseWe),
    .badVariant(badVariant)
  );

  bo_agu_dpath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .baseIn  (baseIn),
    .offsetIn(offsetIn),
    .addUp   (addUp),
    .memAddr (memAddr),
    .baseNew (baseNew)
  );

endmodule

// File: rtl/bo_agu_chk.sv
module bo_agu_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [ADDR_W-1:0] baseIn,
  input logic [OFF_W-1:0]  offsetIn,
  input logic              addUp,
  input logic [1:0]        variant,
  input logic              outValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] baseNew,
  input logic              baseWe,
  input logic              badVariant
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r9_flags_need_valid: assert property (@(posedge clk) disable iff (!rstN)
    (baseWe || badVariant) |-> outValid);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(memAddr) && $stable(baseNew)));

  a_r7_reserved_no_we: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && variant == 2'b11) |=> (badVariant && !baseWe && memAddr == $past(baseIn)));

  a_r3_offset_no_we: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && variant == 2'b00) |=> (!baseWe && memAddr == baseNew));

  a_r4_pre_same_value: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && variant == 2'b01) |=> (baseWe && memAddr == baseNew));

  a_r5_post_old_base: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && variant == 2'b10) |=> (baseWe && memAddr == $past(baseIn)));

  a_r6_add_up: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && addUp) |=> (baseNew == ADDR_W'($past(baseIn) + ADDR_W'($past(offsetIn)))));

  a_r6_sub_down: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !addUp) |=> (baseNew == ADDR_W'($past(baseIn) - ADDR_W'($past(offsetIn)))));

endmodule

bind bo_agu bo_agu_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .baseIn    (baseIn),
  .offsetIn  (offsetIn),
  .addUp     (addUp),
  .variant   (variant),
  .outValid  (outValid),
  .memAddr   (memAddr),
  .baseNew   (baseNew),
  .baseWe    (baseWe),
  .badVariant(badVariant)
);

// File: tb/test_bo_agu.sv
module test_bo_agu;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 8;
  localparam int OW         = 4;
  localparam int MAX_CYC    = 200000;

  logic          clk;
  logic          rstN;
  logic          inValid;
  logic [AW-1:0] baseIn;
  logic [OW-1:0] offsetIn;
  logic          addUp;
  logic [1:0]    variant;
  logic          outValid;
  logic [AW-1:0] memAddr;
  logic [AW-1:0] baseNew;
  logic          baseWe;
  logic          badVariant;

  bo_agu #(.ADDR_W(AW), .OFF_W(OW)) i_bo_agu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .baseIn(baseIn),
    .offsetIn(offsetIn), .addUp(addUp), .variant(variant),
    .outValid(outValid), .memAddr(memAddr), .baseNew(baseNew),
    .baseWe(baseWe), .badVariant(badVariant)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // expected outputs for the coming sample
  logic          eValid, eWe, eBad;
  logic [AW-1:0] eAddr, eBase;
  string         eReq;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkOuts();
    chk((eReq == "R1") ? "R1" : (eValid ? "R2" : "R9"), "outValid", int'(outValid), int'(eValid));
    chk(eReq, "memAddr", int'(memAddr), int'(eAddr));
    chk((eReq == "R1" || eReq == "R9") ? eReq : "R8", "baseNew", int'(baseNew), int'(eBase));
    chk(eReq, "baseWe", int'(baseWe), int'(eWe));
    chk(eReq, "badVariant", int'(badVariant), int'(eBad));
  endtask

  // check the previous result, then drive a new request
  task automatic step(input logic v, input int b, input int o, input logic up, input int code);
    logic [AW-1:0] sum;
    @(negedge clk);
    checkOuts();
    inValid  = v;
    baseIn   = AW'(b);
    offsetIn = OW'(o);
    addUp    = up;
    variant  = 2'(code);
    if (v) begin
      // R6: zero-extended offset, modulo 2^AW
      sum    = up ? AW'(b + o) : AW'(b - o);
      eValid = 1'b1;
      eBase  = sum;
      eAddr  = (code >= 2) ? AW'(b) : sum;
      eWe    = (code == 1) || (code == 2);
      eBad   = (code == 3);
      case (code)
        0:       eReq = "R3";
        1:       eReq = "R4";
        2:       eReq = "R5";
        default: eReq = "R7";
      endcase
    end else begin
      eValid = 1'b0;
      eWe    = 1'b0;
      eBad   = 1'b0;
      eReq   = "R9";
    end
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", MAX_CYC);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; baseIn = '0; offsetIn = '0; addUp = 1'b0; variant = 2'b00;
    eValid = 1'b0; eWe = 1'b0; eBad = 1'b0; eAddr = '0; eBase = '0; eReq = "R1";
    repeat (3) @(negedge clk);
    checkOuts();  // R1 under reset
    rstN = 1'b1;
    @(negedge clk);
    checkOuts();  // R1 after release, no strobe yet
    eReq = "R9";
    for (int b = 0; b < (1 << AW); b++) begin
      for (int code = 0; code < 4; code++)
        for (int up = 0; up < 2; up++)
          for (int o = 0; o < (1 << OW); o++)
            step(1'b1, b, o, up[0], code);
      step(1'b0, (b * 37) & 255, b & 15, b[0], 1);  // R9 idle with changing inputs
    end
    step(1'b1, 3, 9, 1'b0, 3);  // R7 reserved, then idle
    step(1'b0, 0, 0, 1'b0, 0);
    step(1'b0, 1, 1, 1'b1, 2);
    @(negedge clk);
    checkOuts();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule